// File: doc/BRIEF.md
# Winograd Eligibility Gate

This block decides, for one convolution at a time, whether the fast-transform (Winograd) convolution mode may be used and, if so, which of its two tile shapes applies. A scheduler presents the layer description: a chip configuration word, the kernel type code, a unity-kernel flag, the tensor format code, the three kernel extents, the stride, the output-channel group size, the work-unit mode and a float-kernel flag. It then pulses a request strobe. One cycle later the block reports a registered verdict.

Eligibility is a fixed conjunction of tests on enable, format, shape and stride, plus a test that the work term is large enough. The work term is the group size times the product of the kernel extents, times two. Its threshold depends on the work-unit mode and on the kernel data type. When the request is rejected, a reason code names the first test that failed, in a fixed priority order. When the request is accepted, a tile-form code tells the datapath which transform tile to use. The verdict holds until the next request.

Top module: `wg_gate`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `req_i` high. `eligible_o`, `tile_form_o` and `reason_o` reflect the inputs sampled with that request and stay unchanged until the next request is sampled. Input changes without `req_i` have no effect on them.
- R2: A request with bit 0 of `chip_cfg_i` clear is rejected with reason code 1.
- R3: A request with kernel type code 5 or 2, or with `unity_kernel_i` set, is rejected with reason code 2.
- R4: A request with tensor format code 12 is rejected with reason code 3.
- R5: The kernel shape passes only when one of `k_h_i`/`k_w_i` equals 3 and the other axis is 3, 4 or 5. Otherwise the request is rejected with reason code 4.
- R6: A depth extent `k_d_i` other than 1 rejects with reason code 5.
- R7: A stride other than 1 rejects with reason code 6.
- R8: The work term is `grp_i*k_h_i*k_w_i*k_d_i*2`, computed at full width. The request passes when the work term is greater than or equal to the threshold. The threshold is 32 when `wu_mode_i` is 1 or 2. Otherwise it is 16 when `float_kernel_i` is set and 8 when it is clear. A failing work term rejects with reason code 7.
- R9: An eligible result carries reason code 0 and a tile form chosen by the orthogonal axis. Code 1 (output tile 2, input tile 4) is chosen when that axis is 3. Code 2 (output tile 4, input tile 6) is chosen when it is 4 or 5. A rejected result carries tile form 0.
- R10: When several tests fail, the reason code is the lowest code among them. The priority is enable, then kernel type, format, shape, depth, stride, and work last.
- R11: After reset, `valid_o` and `eligible_o` are 0, and `tile_form_o` and `reason_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe; samples all descriptor inputs |
| chip_cfg_i | input | 8 | Chip configuration word; bit 0 enables the mode |
| ktype_i | input | 4 | Kernel underlying type code |
| unity_kernel_i | input | 1 | Kernel is unity/identity |
| tfmt_i | input | 4 | Tensor format code |
| k_h_i | input | 4 | Kernel height |
| k_w_i | input | 4 | Kernel width |
| k_d_i | input | 4 | Kernel depth extent |
| stride_i | input | 4 | Convolution stride |
| grp_i | input | 8 | Output-channel group size |
| wu_mode_i | input | 2 | Work-unit mode |
| float_kernel_i | input | 1 | Kernel data is floating point |
| valid_o | output | 1 | Verdict strobe, one cycle after request |
| eligible_o | output | 1 | Mode may be used |
| tile_form_o | output | 2 | 0 none, 1 out2/in4, 2 out4/in6 |
| reason_o | output | 3 | 0 eligible, else first failing test |

## Verification
The assertions assume that `req_i` is a clean synchronous strobe and that descriptor inputs are stable in any cycle where it is high. They make no assumption about the descriptor values, because any combination must yield a defined verdict. The stimulus changes inputs only on falling edges and holds the strobe for exactly one cycle per request, with idle gaps in which inputs are scrambled to expose any unregistered path. Directed vectors hit each reject code alone and in combination, then a seeded random sweep draws values from small ranges clustered around the codes and extents that matter.

// File: rtl/wg_gate_pkg.sv
package wg_gate_pkg;

  localparam int RSN_W   = 3;
  localparam int TILE_W  = 2;
  localparam int N_TESTS = 7;

  typedef enum logic [RSN_W-1:0] {
    RSN_OK       = 3'd0,
    RSN_DISABLED = 3'd1,
    RSN_KTYPE    = 3'd2,
    RSN_FORMAT   = 3'd3,
    RSN_SHAPE    = 3'd4,
    RSN_DEPTH    = 3'd5,
    RSN_STRIDE   = 3'd6,
    RSN_WORK     = 3'd7
  } reason_e;

  typedef enum logic [TILE_W-1:0] {
    TILE_NONE  = 2'd0,
    TILE_O2_I4 = 2'd1,
    TILE_O4_I6 = 2'd2
  } tile_e;

  // fail vector bit index == reason code - 1 (bit 0 highest priority)
  localparam int FB_DISABLED = 0;
  localparam int FB_KTYPE    = 1;
  localparam int FB_FORMAT   = 2;
  localparam int FB_SHAPE    = 3;
  localparam int FB_DEPTH    = 4;
  localparam int FB_STRIDE   = 5;
  localparam int FB_WORK     = 6;

  localparam int KTYPE_BAN_A = 5;
  localparam int KTYPE_BAN_B = 2;
  localparam int FMT_BAN     = 12;
  localparam int FIXED_AXIS  = 3;
  localparam int ORTH_MIN    = 3;
  localparam int ORTH_MAX    = 5;
  localparam int THR_WU      = 32;
  localparam int THR_FLOAT   = 16;
  localparam int THR_INT     = 8;

endpackage

// File: rtl/wg_shape_classify.sv
module wg_shape_classify
  import wg_gate_pkg::*;
#(
  parameter int DIM_W = 4
) (
  input  logic [DIM_W-1:0]  k_h_i,
  input  logic [DIM_W-1:0]  k_w_i,
  output logic              shape_ok_o,
  output logic [TILE_W-1:0] tile_o
);

  localparam int N_ORIENT = 2;

  logic [N_ORIENT-1:0] orient_ok;
  logic [DIM_W-1:0]    orth [N_ORIENT];

  // orientation 0: height is the fixed axis, 1: width is the fixed axis
  for (genvar g = 0; g < N_ORIENT; g++) begin : g_orient
    logic [DIM_W-1:0] fixed_ax;
    assign fixed_ax     = (g == 0) ? k_h_i : k_w_i;
    assign orth[g]      = (g == 0) ? k_w_i : k_h_i;
    assign orient_ok[g] = (fixed_ax == DIM_W'(FIXED_AXIS)) &&
                          (orth[g] >= DIM_W'(ORTH_MIN)) &&
                          (orth[g] <= DIM_W'(ORTH_MAX));
  end

  logic [DIM_W-1:0] sel_orth;

  always_comb begin
    sel_orth = '0;
    for (int i = N_ORIENT - 1; i >= 0; i--) begin
      if (orient_ok[i]) sel_orth = orth[i];
    end
  end

  assign shape_ok_o = |orient_ok;

  always_comb begin
    tile_o = TILE_NONE;
    if (shape_ok_o) begin
      tile_o = (sel_orth == DIM_W'(FIXED_AXIS)) ? TILE_O2_I4 : TILE_O4_I6;
    end
  end

endmodule

// File: rtl/wg_work_check.sv
module wg_work_check
  import wg_gate_pkg::*;
#(
  parameter int GRP_W = 8,
  parameter int DIM_W = 4,
  parameter int WU_W  = 2
) (
  input  logic [GRP_W-1:0] grp_i,
  input  logic [DIM_W-1:0] k_h_i,
  input  logic [DIM_W-1:0] k_w_i,
  input  logic [DIM_W-1:0] k_d_i,
  input  logic [WU_W-1:0]  wu_mode_i,
  input  logic             float_kernel_i,
  output logic             work_ok_o
);

  localparam int WORK_W = GRP_W + 3 * DIM_W + 1;

  logic [WORK_W-1:0] work;
  logic [WORK_W-1:0] thr;
  logic              wu_heavy;

  assign work = (WORK_W'(grp_i) * WORK_W'(k_h_i) * WORK_W'(k_w_i) *
                 WORK_W'(k_d_i)) << 1;

  assign wu_heavy = (wu_mode_i == WU_W'(1)) || (wu_mode_i == WU_W'(2));

  always_comb begin
    if (wu_heavy)            thr = WORK_W'(THR_WU);
    else if (float_kernel_i) thr = WORK_W'(THR_FLOAT);
    else                     thr = WORK_W'(THR_INT);
  end

  assign work_ok_o = (work >= thr);

endmodule

// File: rtl/wg_reason_pick.sv
module wg_reason_pick
  import wg_gate_pkg::*;
#(
  parameter int N = N_TESTS
) (
  input  logic [N-1:0]     fail_i,
  output logic [RSN_W-1:0] reason_o
);

  always_comb begin
    reason_o = RSN_OK;
    for (int i = N - 1; i >= 0; i--) begin
      if (fail_i[i]) reason_o = RSN_W'(i + 1);
    end
  end

endmodule

// File: rtl/wg_gate.sv
module wg_gate
  import wg_gate_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int TYPE_W = 4,
  parameter int FMT_W  = 4,
  parameter int DIM_W  = 4,
  parameter int GRP_W  = 8,
  parameter int WU_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CFG_W-1:0]  chip_cfg_i,
  input  logic [TYPE_W-1:0] ktype_i,
  input  logic              unity_kernel_i,
  input  logic [FMT_W-1:0]  tfmt_i,
  input  logic [DIM_W-1:0]  k_h_i,
  input  logic [DIM_W-1:0]  k_w_i,
  input  logic [DIM_W-1:0]  k_d_i,
  input  logic [DIM_W-1:0]  stride_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [WU_W-1:0]   wu_mode_i,
  input  logic              float_kernel_i,
  output logic              valid_o,
  output logic              eligible_o,
  output logic [TILE_W-1:0] tile_form_o,
  output logic [RSN_W-1:0]  reason_o
);

  logic              shape_ok;
  logic [TILE_W-1:0] shape_tile;
  logic              work_ok;
  logic [N_TESTS-1:0] fail;
  logic [RSN_W-1:0]  reason_d;

  wg_shape_classify #(.DIM_W(DIM_W)) u_shape (
    .k_h_i      (k_h_i),
    .k_w_i      (k_w_i),
    .shape_ok_o (shape_ok),
    .tile_o     (shape_tile)
  );

  wg_work_check #(.GRP_W(GRP_W), .DIM_W(DIM_W), .WU_W(WU_W)) u_work (
    .grp_i          (grp_i),
    .k_h_i          (k_h_i),
    .k_w_i          (k_w_i),
    .k_d_i          (k_d_i),
    .wu_mode_i      (wu_mode_i),
    .float_kernel_i (float_kernel_i),
    .work_ok_o      (work_ok)
  );

  always_comb begin
    fail              = '0;
    fail[FB_DISABLED] = !chip_cfg_i[0];
    fail[FB_KTYPE]    = (ktype_i == TYPE_W'(KTYPE_BAN_A)) ||
                        (ktype_i == TYPE_W'(KTYPE_BAN_B)) || unity_kernel_i;
    fail[FB_FORMAT]   = (tfmt_i == FMT_W'(FMT_BAN));
    fail[FB_SHAPE]    = !shape_ok;
    fail[FB_DEPTH]    = (k_d_i != DIM_W'(1));
    fail[FB_STRIDE]   = (stride_i != DIM_W'(1));
    fail[FB_WORK]     = !work_ok;
  end

  wg_reason_pick #(.N(N_TESTS)) u_pick (
    .fail_i   (fail),
    .reason_o (reason_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      eligible_o  <= 1'b0;
      tile_form_o <= TILE_NONE;
      reason_o    <= RSN_OK;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        eligible_o  <= ~|fail;
        tile_form_o <= (~|fail) ? shape_tile : TILE_NONE;
        reason_o    <= reason_d;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o) else $error("valid latency"); // R1
  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i)) else $error("spurious valid"); // R1
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> ($stable(eligible_o) && $stable(tile_form_o) && $stable(reason_o)))
    else $error("result changed without request"); // R1
  AST_DISABLED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !chip_cfg_i[0]) |=> (!eligible_o && reason_o == RSN_DISABLED))
    else $error("disabled chip accepted"); // R2
  AST_FORMAT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && chip_cfg_i[0] && !unity_kernel_i &&
     ktype_i != TYPE_W'(KTYPE_BAN_A) && ktype_i != TYPE_W'(KTYPE_BAN_B) &&
     tfmt_i == FMT_W'(FMT_BAN)) |=> (reason_o == RSN_FORMAT))
    else $error("banned format not reported"); // R4
  AST_ELIG_TILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eligible_o |-> (reason_o == RSN_OK && tile_form_o != TILE_NONE))
    else $error("eligible without tile form"); // R9
  AST_REJECT_NO_TILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eligible_o) |-> (reason_o != RSN_OK && tile_form_o == TILE_NONE))
    else $error("reject without reason"); // R10

endmodule

// File: tb/wg_gate_bench.sv
module wg_gate_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] cfg = '0;
  logic [3:0] ktype = '0;
  logic       unity = 1'b0;
  logic [3:0] tfmt = '0;
  logic [3:0] kh = '0, kw = '0, kd = '0, strd = '0;
  logic [7:0] grp = '0;
  logic [1:0] wu = '0;
  logic       flt = 1'b0;
  logic       valid, elig;
  logic [1:0] tile;
  logic [2:0] rsn;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] exp_q[$];
  logic [5:0] last_exp = '0;
  string      tag_q[$];

  always #2 clk = ~clk;

  wg_gate u_wg_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chip_cfg_i(cfg),
    .ktype_i(ktype), .unity_kernel_i(unity), .tfmt_i(tfmt),
    .k_h_i(kh), .k_w_i(kw), .k_d_i(kd), .stride_i(strd), .grp_i(grp),
    .wu_mode_i(wu), .float_kernel_i(flt),
    .valid_o(valid), .eligible_o(elig), .tile_form_o(tile), .reason_o(rsn)
  );

  // {eligible, tile[1:0], reason[2:0]}
  function automatic logic [5:0] model(
    logic [7:0] c, logic [3:0] kt, logic un, logic [3:0] tf,
    logic [3:0] h, logic [3:0] w, logic [3:0] d, logic [3:0] s,
    logic [7:0] g, logic [1:0] m, logic fl);
    int orth, work, thr;
    bit shape;
    logic [2:0] r;
    logic [1:0] t;
    orth = -1;
    if (h == 3 && w >= 3 && w <= 5) orth = w;
    else if (w == 3 && h >= 3 && h <= 5) orth = h;
    shape = (orth != -1);
    work = int'(g) * int'(h) * int'(w) * int'(d) * 2;
    thr  = (m == 1 || m == 2) ? 32 : (fl ? 16 : 8);
    if (!c[0])                          r = 3'd1;
    else if (kt == 5 || kt == 2 || un)  r = 3'd2;
    else if (tf == 12)                  r = 3'd3;
    else if (!shape)                    r = 3'd4;
    else if (d != 1)                    r = 3'd5;
    else if (s != 1)                    r = 3'd6;
    else if (work < thr)                r = 3'd7;
    else                                r = 3'd0;
    t = (r != 0) ? 2'd0 : ((orth == 3) ? 2'd1 : 2'd2);
    return {(r == 0), t, r};
  endfunction

  task automatic check(string req_tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got elig=%0b tile=%0d rsn=%0d, expected elig=%0b tile=%0d rsn=%0d",
               req_tag, act[5], act[4:3], act[2:0], exp[5], exp[4:3], exp[2:0]);
    end
  endtask

  task automatic apply(string req_tag, logic [7:0] c, logic [3:0] kt, logic un,
                       logic [3:0] tf, logic [3:0] h, logic [3:0] w, logic [3:0] d,
                       logic [3:0] s, logic [7:0] g, logic [1:0] m, logic fl);
    logic [5:0] e;
    e = model(c, kt, un, tf, h, w, d, s, g, m, fl);
    exp_q.push_back(e);
    tag_q.push_back(req_tag);
    last_exp = e;
    @(negedge clk);
    cfg = c; ktype = kt; unity = un; tfmt = tf; kh = h; kw = w; kd = d;
    strd = s; grp = g; wu = m; flt = fl; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: compare each verdict against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (valid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R1: valid with empty scoreboard, got 1 expected 0");
        end else begin
          logic [5:0] e;
          string      tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(tg, {elig, tile, rsn}, e);
        end
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", {elig, tile, rsn}, 6'd0);
    n_chk++;
    if (valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: valid got %0b expected 0", valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 eligible forms
    apply("R9 3x3 float",    8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd1, 2'd0, 1);
    apply("R9 3x4",          8'h01, 4'd1, 0, 4'd1, 4'd3, 4'd4, 4'd1, 4'd1, 8'd1, 2'd0, 0);
    apply("R9 5x3",          8'h81, 4'd3, 0, 4'd0, 4'd5, 4'd3, 4'd1, 4'd1, 8'd2, 2'd1, 0);
    // single failures
    apply("R2 disabled",     8'hFE, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R3 ktype 5",      8'h01, 4'd5, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R3 ktype 2",      8'h01, 4'd2, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R3 unity",        8'h01, 4'd0, 1, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R4 format 12",    8'h01, 4'd0, 0, 4'd12, 4'd3, 4'd3, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R5 3x6",          8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd6, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R5 5x5",          8'h01, 4'd0, 0, 4'd0, 4'd5, 4'd5, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R5 3x2",          8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd2, 4'd1, 4'd1, 8'd4, 2'd0, 0);
    apply("R6 depth 2",      8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd2, 4'd1, 8'd4, 2'd0, 0);
    apply("R7 stride 2",     8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd2, 8'd4, 2'd0, 0);
    // R8 threshold boundaries: 3x3 gives 18*grp
    apply("R8 grp0 int",     8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd0, 2'd0, 0);
    apply("R8 wu1 18<32",    8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd1, 2'd1, 0);
    apply("R8 wu2 18<32",    8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd1, 2'd2, 1);
    apply("R8 wu3 18>=16",   8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd1, 2'd3, 1);
    apply("R8 wu1 36>=32",   8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd1, 8'd2, 2'd1, 0);
    apply("R8 3x5 30<32",    8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd5, 4'd1, 4'd1, 8'd1, 2'd2, 0);
    apply("R8 3x4 24<32",    8'h01, 4'd0, 0, 4'd0, 4'd4, 4'd3, 4'd1, 4'd1, 8'd1, 2'd1, 0);
    apply("R8 3x5 30>=16",   8'h01, 4'd0, 0, 4'd0, 4'd5, 4'd3, 4'd1, 4'd1, 8'd1, 2'd0, 1);
    // R10 priority with multiple failures
    apply("R10 all fail",    8'h00, 4'd5, 1, 4'd12, 4'd7, 4'd7, 4'd2, 4'd2, 8'd0, 2'd1, 0);
    apply("R10 fmt+shape",   8'h01, 4'd0, 0, 4'd12, 4'd7, 4'd7, 4'd2, 4'd2, 8'd0, 2'd1, 0);
    apply("R10 depth+work",  8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd0, 4'd3, 8'd0, 2'd1, 0);
    apply("R10 stride+work", 8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd3, 4'd1, 4'd0, 8'd0, 2'd0, 0);

    // R1: result held while inputs wander without a request
    apply("R1 hold base",    8'h01, 4'd0, 0, 4'd0, 4'd3, 4'd4, 4'd1, 4'd1, 8'd3, 2'd0, 1);
    @(negedge clk);
    cfg = 8'h00; kh = 4'd9; tfmt = 4'd12; grp = 8'd0;
    repeat (3) @(negedge clk);
    check("R1 hold", {elig, tile, rsn}, last_exp);
    n_chk++;
    if (valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: valid got %0b expected 0 while idle", valid);
    end

    // seeded random sweep
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rk, rh, rw;
      rk = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      rh = ($urandom_range(0, 1) == 0) ? 4'd3 : 4'($urandom_range(1, 7));
      rw = ($urandom_range(0, 1) == 0) ? 4'd3 : 4'($urandom_range(1, 7));
      apply("R10 random",
            8'($urandom_range(0, 7) == 0 ? 0 : 1 | ($urandom_range(0, 127) << 1)),
            rk, ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 5) == 0) ? 4'd12 : 4'($urandom_range(0, 11)),
            rh, rw,
            ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 3)) : 4'd1,
            ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 3)) : 4'd1,
            8'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d verdicts missing, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule